// File: doc/BRIEF.md
# Indexed Super I/O Configuration Port

This block gives a host a two-byte window into the setup of a legacy peripheral controller. The window has an index port and a data port. A byte written to the index port picks one of 256 byte registers. The next access to the data port reads or writes that register. The index itself lives in register 0, so a data access at index 0 never exposes it.

Some registers act as the live configuration of the peripherals behind the controller. These are one function-select byte and four base-address bytes. Writes to them are masked as they are stored. The stored values are decoded into enables and 10-bit I/O base addresses for a parallel port, two serial ports and a floppy controller. Many indices are read-only, and a data write to them is dropped without any effect. The enclosing bridge drives an enable input. While that input is low, both ports ignore writes, and every read returns 0xFF.

Top module: `sio_cfg_top`

## Requirements
- R1: A write to port 0 (acc_port=0) stores the byte as the index. A read of port 0 returns the current index. A data write (acc_port=1) never changes the index.
- R2: A read of port 1 returns the register selected by the index. The one exception is index 0x00, which reads as 0x00.
- R3: A data write is dropped when the index is 0x00-0xDF, 0xE4, 0xE5, 0xE9-0xED, 0xF3, 0xF5, 0xF7, 0xF9-0xFB or 0xFD-0xFF.
- R4: A data write to index 0xE2 stores data AND 0x1F. From the stored value: par_en=1 unless bits 1:0 are both 1; ser_en[n]=bit n+2 for n=0,1; fdc_en=bit 4.
- R5: A data write to index 0xE3 stores data AND 0xFC, and fdc_base = stored value << 2.
- R6: A data write to index 0xE6 stores the full byte, and par_base = stored value << 2.
- R7: Data writes to 0xE7 and 0xE8 store data AND 0xFE. ser0_base and ser1_base are the respective stored values << 2.
- R8: A data write to any other writable index (0xE0, 0xE1, 0xEE-0xF2, 0xF4, 0xF6, 0xF8, 0xFC) stores the byte unchanged.
- R9: After reset the registers hold the following values, and every other register is 0x00:
  - 0xE0=0x3C
  - 0xE2=0x0F
  - 0xE3=0xFC
  - 0xE6=0xDE
  - 0xE7=0xFE
  - 0xE8=0xBE
  - index=0x00

  As a result, fdc_base=0x3F0, par_base=0x378, ser0_base=0x3F8, ser1_base=0x2F8, both serial ports are enabled, and par_en=fdc_en=0.
- R10: While port_en=0, writes to either port are ignored and reads return 0xFF.
- R11: A read accepted on a clock edge sets rd_valid and rd_data on that same edge, and they hold for one cycle. Decoded outputs reflect a write from the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Enables response of both ports |
| acc_valid | input | 1 | Single-byte access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 1 | 0 = index port, 1 = data port |
| acc_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read byte |
| par_en | output | 1 | Parallel port enable |
| ser_en | output | 2 | Serial port enables, bit n = port n |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 10 | Floppy I/O base |
| par_base | output | 10 | Parallel I/O base |
| ser0_base | output | 10 | Serial port 0 I/O base |
| ser1_base | output | 10 | Serial port 1 I/O base |

## Verification
Read results are registered once, so rd_valid and rd_data are due on the edge that accepts the read. Decoded enables and bases follow the register file combinationally, so they change on the edge that accepts the write. The bench drives each access on a falling edge. It samples both kinds of result on the next falling edge, half a period after the edge where they become due. Read-only and disabled writes are checked by reading the target register or the decoded output back through the ports afterwards.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 8;
    localparam int NREG       = 1 << IDX_W;
    localparam int ADDR_SHIFT = 2;
    localparam int BASE_W     = BYTE_W + ADDR_SHIFT;
    localparam int NUM_SER    = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [BASE_W-1:0] base_t;

    typedef enum logic [2:0] {
        WC_RO, WC_PLAIN, WC_FSEL, WC_FDC, WC_PAR, WC_SER0, WC_SER1
    } wclass_e;

    localparam byte_t IX_DEVID = 8'hE0;
    localparam byte_t IX_FSEL  = 8'hE2;
    localparam byte_t IX_FDC   = 8'hE3;
    localparam byte_t IX_PAR   = 8'hE6;
    localparam byte_t IX_SER0  = 8'hE7;
    localparam byte_t IX_SER1  = 8'hE8;

    typedef struct packed {
        logic  we;
        byte_t addr;
        byte_t data;
    } wr_req_t;

    function automatic logic is_read_only(byte_t ix);
        return (ix <= 8'hDF) || (ix == 8'hE4) || (ix == 8'hE5) ||
               (ix >= 8'hE9 && ix <= 8'hED) || (ix == 8'hF3) ||
               (ix == 8'hF5) || (ix == 8'hF7) ||
               (ix >= 8'hF9 && ix <= 8'hFB) || (ix >= 8'hFD);
    endfunction

    function automatic wclass_e classify(byte_t ix);
        if (is_read_only(ix)) return WC_RO;
        case (ix)
            IX_FSEL: return WC_FSEL;
            IX_FDC:  return WC_FDC;
            IX_PAR:  return WC_PAR;
            IX_SER0: return WC_SER0;
            IX_SER1: return WC_SER1;
            default: return WC_PLAIN;
        endcase
    endfunction

    function automatic byte_t store_mask(wclass_e c);
        case (c)
            WC_FSEL:          return 8'h1F;
            WC_FDC:           return 8'hFC;
            WC_SER0, WC_SER1: return 8'hFE;
            default:          return 8'hFF;
        endcase
    endfunction

    function automatic byte_t reset_value(byte_t ix);
        case (ix)
            IX_DEVID: return 8'h3C;
            IX_FSEL:  return 8'h0F;
            IX_FDC:   return 8'hFC;
            IX_PAR:   return 8'hDE;
            IX_SER0:  return 8'hFE;
            IX_SER1:  return 8'hBE;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic base_t to_base(byte_t v);
        return {v, {ADDR_SHIFT{1'b0}}};
    endfunction
endpackage

// File: rtl/sio_wr_path.sv
module sio_wr_path
    import sio_cfg_pkg::*;
(
    input  logic    acc_valid,
    input  logic    acc_write,
    input  logic    acc_port,
    input  byte_t   acc_wdata,
    input  logic    port_en,
    input  byte_t   idx_q,
    output wr_req_t wr
);
    wclass_e cls;

    always_comb begin
        cls     = classify(idx_q);
        wr.we   = 1'b0;
        wr.addr = '0;
        wr.data = acc_wdata;
        if (acc_valid && acc_write && port_en) begin
            if (!acc_port) begin
                wr.we = 1'b1;
            end else if (cls != WC_RO) begin
                wr.we   = 1'b1;
                wr.addr = idx_q;
                wr.data = acc_wdata & store_mask(cls);
            end
        end
    end
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
    import sio_cfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr,
    input  byte_t   rd_addr,
    output byte_t   rd_byte,
    output byte_t   idx_q,
    output byte_t   fsel_q,
    output byte_t   fdc_q,
    output byte_t   par_q,
    output byte_t   ser_q [NUM_SER]
);
    byte_t mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= reset_value(byte_t'(i));
        end else if (wr.we) begin
            mem[wr.addr] <= wr.data;
        end
    end

    assign rd_byte = mem[rd_addr];
    assign idx_q   = mem[0];
    assign fsel_q  = mem[IX_FSEL];
    assign fdc_q   = mem[IX_FDC];
    assign par_q   = mem[IX_PAR];

    for (genvar n = 0; n < NUM_SER; n++) begin : g_ser_tap
        assign ser_q[n] = mem[IX_SER0 + byte_t'(n)];
    end

    assert_ro_guard_R3: assert property (@(posedge clk) disable iff (rst)
        (wr.we && wr.addr != 8'h00) |-> !is_read_only(wr.addr));
endmodule

// File: rtl/sio_decode.sv
module sio_decode
    import sio_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  byte_t               fsel_q,
    input  byte_t               fdc_q,
    input  byte_t               par_q,
    input  byte_t               ser_q [NUM_SER],
    output logic                par_en,
    output logic [NUM_SER-1:0]  ser_en,
    output logic                fdc_en,
    output base_t               fdc_base,
    output base_t               par_base,
    output base_t               ser_base [NUM_SER]
);
    assign par_en   = (fsel_q[1:0] != 2'b11);
    assign fdc_en   = fsel_q[4];
    assign fdc_base = to_base(fdc_q);
    assign par_base = to_base(par_q);

    for (genvar n = 0; n < NUM_SER; n++) begin : g_ser
        assign ser_en[n]   = fsel_q[n + 2];
        assign ser_base[n] = to_base(ser_q[n]);

        assert_ser_align_R7: assert property (@(posedge clk) disable iff (rst)
            ser_base[n][2:0] == 3'b000);
    end

    assert_fdc_align_R5: assert property (@(posedge clk) disable iff (rst)
        fdc_base[3:0] == 4'h0);
    assert_fsel_width_R4: assert property (@(posedge clk) disable iff (rst)
        fsel_q[7:5] == 3'b000);
endmodule

// File: rtl/sio_cfg_top.sv
module sio_cfg_top
    import sio_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        port_en,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_port,
    input  logic [7:0]  acc_wdata,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        par_en,
    output logic [1:0]  ser_en,
    output logic        fdc_en,
    output logic [9:0]  fdc_base,
    output logic [9:0]  par_base,
    output logic [9:0]  ser0_base,
    output logic [9:0]  ser1_base
);
    wr_req_t wr;
    byte_t   idx_q, rd_byte, fsel_q, fdc_q, par_q;
    byte_t   ser_q [NUM_SER];
    base_t   ser_base [NUM_SER];

    sio_wr_path u_wr (
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_port(acc_port),
        .acc_wdata(acc_wdata), .port_en(port_en), .idx_q(idx_q), .wr(wr)
    );

    sio_regfile u_rf (
        .clk(clk), .rst(rst), .wr(wr), .rd_addr(idx_q), .rd_byte(rd_byte),
        .idx_q(idx_q), .fsel_q(fsel_q), .fdc_q(fdc_q), .par_q(par_q),
        .ser_q(ser_q)
    );

    sio_decode u_dec (
        .clk(clk), .rst(rst), .fsel_q(fsel_q), .fdc_q(fdc_q), .par_q(par_q),
        .ser_q(ser_q), .par_en(par_en), .ser_en(ser_en), .fdc_en(fdc_en),
        .fdc_base(fdc_base), .par_base(par_base), .ser_base(ser_base)
    );

    assign ser0_base = ser_base[0];
    assign ser1_base = ser_base[1];

    logic rd_acc;
    assign rd_acc = acc_valid && !acc_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_acc;
            if (rd_acc) begin
                if (!port_en)            rd_data <= 8'hFF;
                else if (!acc_port)      rd_data <= idx_q;
                else if (idx_q == 8'h00) rd_data <= 8'h00;
                else                     rd_data <= rd_byte;
            end
        end
    end

    assert_idx_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_port) |=> $stable(idx_q));
    assert_idx_read_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && port_en && !acc_port) |=> rd_data == $past(idx_q));
    assert_idx0_read_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && port_en && acc_port && idx_q == 8'h00) |=> rd_data == 8'h00);
    assert_off_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && !port_en) |=> rd_data == 8'hFF);
    assert_off_write_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !port_en) |=> $stable(idx_q));
    assert_rd_valid_R11: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> rd_valid);
endmodule

// File: tb/sio_cfg_top_tb.sv
module sio_cfg_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_en = 1'b1;
    logic       acc_valid = 1'b0, acc_write = 1'b0, acc_port = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic       rd_valid, par_en, fdc_en;
    logic [7:0] rd_data;
    logic [1:0] ser_en;
    logic [9:0] fdc_base, par_base, ser0_base, ser1_base;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sio_cfg_top dut_i (
        .clk(clk), .rst(rst), .port_en(port_en), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_port(acc_port), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .par_en(par_en),
        .ser_en(ser_en), .fdc_en(fdc_en), .fdc_base(fdc_base),
        .par_base(par_base), .ser0_base(ser0_base), .ser1_base(ser1_base)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(bit port, logic [7:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_port = port; acc_wdata = d;
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic rd(bit port, output logic [7:0] d, output logic v);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_port = port;
        @(negedge clk);
        acc_valid = 0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic reg_read(logic [7:0] ix, output logic [7:0] d);
        logic v;
        wr(0, ix);
        rd(1, d, v);
    endtask

    task automatic t_reset;
        logic [7:0] d; logic v;
        check("R11 idle rd_valid", rd_valid, 0);
        check("R9 fdc_base", fdc_base, 10'h3F0);
        check("R9 par_base", par_base, 10'h378);
        check("R9 ser0_base", ser0_base, 10'h3F8);
        check("R9 ser1_base", ser1_base, 10'h2F8);
        check("R9 enables", {par_en, ser_en, fdc_en}, 4'b0110);
        rd(0, d, v);
        check("R9 index", d, 8'h00);
        check("R11 rd_valid", v, 1);
        reg_read(8'hE0, d); check("R9 reg E0", d, 8'h3C);
        reg_read(8'hE2, d); check("R9 reg E2", d, 8'h0F);
        reg_read(8'h40, d); check("R9 reg 40", d, 8'h00);
    endtask

    task automatic t_index;
        logic [7:0] d; logic v;
        wr(0, 8'h5A); rd(0, d, v);
        check("R1 index readback", d, 8'h5A);
        wr(0, 8'hEE); wr(1, 8'h77); rd(0, d, v);
        check("R1 index after data write", d, 8'hEE);
        wr(0, 8'h00); rd(1, d, v);
        check("R2 index 0 reads zero", d, 8'h00);
        wr(1, 8'h33); rd(0, d, v);
        check("R3 data write at index 0", d, 8'h00);
    endtask

    task automatic t_readonly;
        logic [7:0] d;
        wr(0, 8'h10); wr(1, 8'hAB); reg_read(8'h10, d);
        check("R3 reg 10", d, 8'h00);
        wr(0, 8'hE4); wr(1, 8'hAB); reg_read(8'hE4, d);
        check("R3 reg E4", d, 8'h00);
        wr(0, 8'hEB); wr(1, 8'hAB); reg_read(8'hEB, d);
        check("R3 reg EB", d, 8'h00);
        wr(0, 8'hFF); wr(1, 8'hAB); reg_read(8'hFF, d);
        check("R3 reg FF", d, 8'h00);
    endtask

    task automatic t_fsel;
        logic [7:0] d;
        wr(0, 8'hE2); wr(1, 8'hFF);
        check("R4 enables all", {par_en, ser_en, fdc_en}, 4'b0111);
        reg_read(8'hE2, d); check("R4 stored masked", d, 8'h1F);
        wr(0, 8'hE2); wr(1, 8'h01);
        check("R4 enables par only", {par_en, ser_en, fdc_en}, 4'b1000);
        wr(0, 8'hE2); wr(1, 8'h16);
        check("R4 enables mix", {par_en, ser_en, fdc_en}, 4'b1011);
    endtask

    task automatic t_bases;
        logic [7:0] d;
        wr(0, 8'hE3); wr(1, 8'h37);
        check("R5 fdc_base", fdc_base, 10'h0D0);
        reg_read(8'hE3, d); check("R5 stored", d, 8'h34);
        wr(0, 8'hE6); wr(1, 8'h41);
        check("R6 par_base", par_base, 10'h104);
        wr(0, 8'hE7); wr(1, 8'hFF);
        check("R7 ser0_base", ser0_base, 10'h3F8);
        wr(0, 8'hE8); wr(1, 8'h13);
        check("R7 ser1_base", ser1_base, 10'h048);
        reg_read(8'hE8, d); check("R7 stored", d, 8'h12);
    endtask

    task automatic t_plain;
        logic [7:0] d;
        wr(0, 8'hEE); wr(1, 8'hA5); reg_read(8'hEE, d);
        check("R8 reg EE", d, 8'hA5);
        wr(0, 8'hFC); wr(1, 8'h81); reg_read(8'hFC, d);
        check("R8 reg FC", d, 8'h81);
    endtask

    task automatic t_gate;
        logic [7:0] d; logic v;
        wr(0, 8'hE6);
        port_en = 0;
        wr(1, 8'h11);
        check("R10 par_base unchanged", par_base, 10'h104);
        wr(0, 8'h99);
        rd(0, d, v); check("R10 disabled read", d, 8'hFF);
        check("R11 rd_valid when disabled", v, 1);
        port_en = 1;
        rd(0, d, v); check("R10 index unchanged", d, 8'hE6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_index;
        t_readonly;
        t_fsel;
        t_bases;
        t_plain;
        t_gate;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule